// File: doc/BRIEF.md
# Two-Level Trap Frame Controller

This block handles trap entry and trap return for a processor whose 27-trit words are balanced-ternary. Each trit travels as a 2-bit code: 00 is Z, 01 is P and 10 is N. The code 11 is illegal, and every input treats it as Z. The block holds the status word and the trap vector. It also holds two save banks: a primary bank and a nested bank. A three-valued depth field inside the status word picks which bank a trap fills and which bank a trap return reads.

A trap request carries a kind, a call flavour and an info word. From these the block forms the cause code and the trap value, saves the interrupted state into the bank that the depth selects, and raises a redirect to the trap vector on the next cycle. When both banks are full, a further trap clears every stored register and raises a one-cycle machine-check pulse. The rest of the core uses that pulse to wipe its own registers and restart at address 0.

Software reaches all stored registers through a CSR port with a combinational read. Writes complete at the clock edge. Every pin is a plain level or strobe with no handshake. The block accepts a trap or a return in any cycle and never stalls its neighbours, so none of its interfaces has back-pressure.

Top module: `trap_bank_ctrl`

## Requirements
- R1: After reset, `status_out` is zero, `redirect_valid` and `mcheck_reset` are low, and every stored CSR reads zero.
- R2: Status trit 0 is the mode, trit 1 is interrupt-enable and trit 2 is the depth. A trap taken at depth Z does the following:
  - copies the old status into the primary saved-status register (address 8), `cur_pc` into the primary return PC (4), the cause into 5 and the trap value into 9;
  - sets mode and interrupt-enable to N and depth to P, and leaves all other status trits unchanged;
  - drives `redirect_valid` high with `redirect_pc` equal to the vector register (6) on the next cycle.
- R3: A trap taken at depth P fills the nested bank: return PC at 10, cause at 11, saved status at 12 and trap value at 13. It sets depth to N, leaves the other status trits unchanged, leaves the primary bank untouched and redirects to the vector register.
- R4: A trap taken at depth N clears every stored CSR and the status word. On the next cycle it gives `mcheck_reset` high for exactly one cycle, with `redirect_valid` high and `redirect_pc` zero.
- R5: A trap return at depth P loads status from address 8 and redirects to address 4. At depth N it loads status from 12 and redirects to 10. At depth Z it does nothing.
- R6: `trap_kind` selects the cause: 00 gives -13 (divide by zero), 01 gives -11 (access fault), 10 gives -10 (illegal instruction) and 11 gives a call. The trap value is `trap_info` for kinds 01 and 10, and zero otherwise.
- R7: For a call, `trap_flavor` picks the cause: Z gives 0 (user call), P gives +1 (hypercall) and N gives +2 (debug trap). Flavour code 11 counts as Z.
- R8: CSR map:
  - 1 is PC and reads `cur_pc`; writes to it are ignored;
  - 2 is logic mode, 3 is flags, 4 is primary return PC, 5 is primary cause, 6 is vector, 7 is status;
  - 8 is primary saved status, 9 is primary trap value;
  - 10 to 13 are the nested return PC, cause, saved status and trap value;
  - any other address reads zero.
- R9: Trit code 11 on `csr_wdata`, `trap_info` or `cur_pc` is stored and reported as Z (00).
- R10: When a trap request and a trap return come in the same cycle, the trap is taken and the return is dropped. A CSR write is dropped in any cycle that holds a trap request or a trap return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Synchronous trap request |
| trap_kind | input | 2 | Trap class (R6 encoding) |
| trap_flavor | input | 2 | Call flavour trit |
| trap_info | input | 54 | Faulting address or raw instruction word |
| cur_pc | input | 54 | PC of the trapping instruction |
| trap_ret | input | 1 | Trap-return strobe |
| csr_we | input | 1 | CSR write enable |
| csr_addr | input | 4 | CSR address |
| csr_wdata | input | 54 | CSR write data |
| csr_rdata | output | 54 | CSR read data (combinational) |
| status_out | output | 54 | Current status word |
| redirect_valid | output | 1 | PC redirect, one cycle after a trap or return |
| redirect_pc | output | 54 | Redirect target |
| mcheck_reset | output | 1 | Machine-check clear request |

## Verification
Three things can arrive in the same cycle: a trap, a trap return and a CSR write. The bench drives all three together at depth P. It then checks that the nested bank filled, that the status went to depth N with no restore, and that the CSR write target kept its old value. Random traffic keeps producing the same clashes at every depth, and each result is judged against a behavioural model that is updated on every clock.

// File: rtl/trap_bank_pkg.sv
package trap_bank_pkg;
  localparam int WORD_TRITS = 27;

  typedef logic [1:0] trit_t;
  localparam trit_t T_Z = 2'b00;
  localparam trit_t T_P = 2'b01;
  localparam trit_t T_N = 2'b10;

  // trit positions inside the status word
  localparam int ST_MODE  = 0;
  localparam int ST_IE    = 1;
  localparam int ST_DEPTH = 2;

  localparam logic [1:0] KIND_DIV0    = 2'b00;
  localparam logic [1:0] KIND_FAULT   = 2'b01;
  localparam logic [1:0] KIND_ILLEGAL = 2'b10;
  localparam logic [1:0] KIND_CALL    = 2'b11;

  localparam int CAUSE_DIV0    = -13;
  localparam int CAUSE_FAULT   = -11;
  localparam int CAUSE_ILLEGAL = -10;
  localparam int CAUSE_UCALL   = 0;
  localparam int CAUSE_HCALL   = 1;
  localparam int CAUSE_DCALL   = 2;

  // CSR addresses
  localparam int A_PC      = 1;
  localparam int A_LMODE   = 2;
  localparam int A_FLAGS   = 3;
  localparam int A_RPC0    = 4;
  localparam int A_CAUSE0  = 5;
  localparam int A_VECTOR  = 6;
  localparam int A_STATUS  = 7;
  localparam int A_SAVE0   = 8;
  localparam int A_TVAL0   = 9;
  localparam int A_RPC1    = 10;
  localparam int A_CAUSE1  = 11;
  localparam int A_SAVE1   = 12;
  localparam int A_TVAL1   = 13;

  // field selector inside a save bank
  localparam logic [1:0] FLD_RPC   = 2'd0;
  localparam logic [1:0] FLD_CAUSE = 2'd1;
  localparam logic [1:0] FLD_SAVE  = 2'd2;
  localparam logic [1:0] FLD_TVAL  = 2'd3;

  function automatic trit_t trit_clean(trit_t t);
    return (t == 2'b11) ? T_Z : t;
  endfunction
endpackage

// File: rtl/trap_cause_encode.sv
module trap_cause_encode
  import trap_bank_pkg::*;
#(
  parameter int TRITS = WORD_TRITS,
  localparam int W = 2 * TRITS
) (
  input  logic [1:0]   kind,
  input  logic [1:0]   flavor,
  input  logic [W-1:0] info,
  output logic [W-1:0] cause,
  output logic [W-1:0] tval
);
  function automatic logic [W-1:0] int_to_word(int v);
    logic [W-1:0] w;
    int rest;
    int r;
    w = '0;
    rest = v;
    for (int i = 0; i < TRITS; i++) begin
      r = rest % 3;
      if (r < 0) r = r + 3;
      if (r == 1) begin
        w[2*i +: 2] = T_P;
        rest = (rest - 1) / 3;
      end else if (r == 2) begin
        w[2*i +: 2] = T_N;
        rest = (rest + 1) / 3;
      end else begin
        rest = rest / 3;
      end
    end
    return w;
  endfunction

  localparam logic [W-1:0] W_DIV0    = int_to_word(CAUSE_DIV0);
  localparam logic [W-1:0] W_FAULT   = int_to_word(CAUSE_FAULT);
  localparam logic [W-1:0] W_ILLEGAL = int_to_word(CAUSE_ILLEGAL);
  localparam logic [W-1:0] W_UCALL   = int_to_word(CAUSE_UCALL);
  localparam logic [W-1:0] W_HCALL   = int_to_word(CAUSE_HCALL);
  localparam logic [W-1:0] W_DCALL   = int_to_word(CAUSE_DCALL);

  trit_t flav_c;
  assign flav_c = trit_clean(flavor);

  always_comb begin
    cause = W_DIV0;
    tval  = '0;
    unique case (kind)
      KIND_DIV0:    cause = W_DIV0;
      KIND_FAULT: begin
        cause = W_FAULT;
        tval  = info;
      end
      KIND_ILLEGAL: begin
        cause = W_ILLEGAL;
        tval  = info;
      end
      default: begin
        if (flav_c == T_P)      cause = W_HCALL;
        else if (flav_c == T_N) cause = W_DCALL;
        else                    cause = W_UCALL;
      end
    endcase
  end
endmodule

// File: rtl/trap_save_bank.sv
module trap_save_bank
  import trap_bank_pkg::*;
#(
  parameter int TRITS = WORD_TRITS,
  localparam int W = 2 * TRITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         capture,
  input  logic [W-1:0] cap_rpc,
  input  logic [W-1:0] cap_save,
  input  logic [W-1:0] cap_cause,
  input  logic [W-1:0] cap_tval,
  input  logic         wr_en,
  input  logic [1:0]   wr_fld,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rpc_q,
  output logic [W-1:0] save_q,
  output logic [W-1:0] cause_q,
  output logic [W-1:0] tval_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rpc_q   <= '0;
      save_q  <= '0;
      cause_q <= '0;
      tval_q  <= '0;
    end else if (capture) begin
      rpc_q   <= cap_rpc;
      save_q  <= cap_save;
      cause_q <= cap_cause;
      tval_q  <= cap_tval;
    end else if (wr_en) begin
      unique case (wr_fld)
        FLD_RPC:   rpc_q   <= wr_data;
        FLD_CAUSE: cause_q <= wr_data;
        FLD_SAVE:  save_q  <= wr_data;
        default:   tval_q  <= wr_data;
      endcase
    end
  end
endmodule

// File: rtl/trap_bank_ctrl.sv
module trap_bank_ctrl
  import trap_bank_pkg::*;
#(
  parameter int TRITS  = WORD_TRITS,
  parameter int ADDR_W = 4,
  localparam int W     = 2 * TRITS,
  localparam int NBANK = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req,
  input  logic [1:0]        trap_kind,
  input  logic [1:0]        trap_flavor,
  input  logic [W-1:0]      trap_info,
  input  logic [W-1:0]      cur_pc,
  input  logic              trap_ret,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [W-1:0]      csr_wdata,
  output logic [W-1:0]      csr_rdata,
  output logic [W-1:0]      status_out,
  output logic              redirect_valid,
  output logic [W-1:0]      redirect_pc,
  output logic              mcheck_reset
);
  // input normalisation: code 11 reads as Z
  logic [W-1:0] info_c, pc_c, wdata_c;
  for (genvar g = 0; g < TRITS; g++) begin : g_clean
    assign info_c[2*g +: 2]  = trit_clean(trap_info[2*g +: 2]);
    assign pc_c[2*g +: 2]    = trit_clean(cur_pc[2*g +: 2]);
    assign wdata_c[2*g +: 2] = trit_clean(csr_wdata[2*g +: 2]);
  end

  logic [W-1:0] status_q, lmode_q, flags_q, vector_q;
  logic [W-1:0] cause_w, tval_w;

  trap_cause_encode #(.TRITS(TRITS)) u_cause (
    .kind   (trap_kind),
    .flavor (trap_flavor),
    .info   (info_c),
    .cause  (cause_w),
    .tval   (tval_w)
  );

  trit_t depth;
  assign depth = status_q[2*ST_DEPTH +: 2];

  logic enter0, enter1, triple, ret_take, ret_sel, wr_ok;
  assign enter0   = trap_req && (depth == T_Z);
  assign enter1   = trap_req && (depth == T_P);
  assign triple   = trap_req && (depth == T_N);
  assign ret_take = trap_ret && !trap_req && (depth != T_Z);
  assign ret_sel  = (depth == T_N);
  assign wr_ok    = csr_we && !trap_req && !trap_ret;

  int unsigned addr_i;
  assign addr_i = int'(csr_addr);

  // bank write decode
  logic [NBANK-1:0] bk_wr;
  logic [1:0]       bk_fld;
  always_comb begin
    bk_wr  = '0;
    bk_fld = FLD_RPC;
    if (wr_ok) begin
      unique case (addr_i)
        A_RPC0:   begin bk_wr[0] = 1'b1; bk_fld = FLD_RPC;   end
        A_CAUSE0: begin bk_wr[0] = 1'b1; bk_fld = FLD_CAUSE; end
        A_SAVE0:  begin bk_wr[0] = 1'b1; bk_fld = FLD_SAVE;  end
        A_TVAL0:  begin bk_wr[0] = 1'b1; bk_fld = FLD_TVAL;  end
        A_RPC1:   begin bk_wr[1] = 1'b1; bk_fld = FLD_RPC;   end
        A_CAUSE1: begin bk_wr[1] = 1'b1; bk_fld = FLD_CAUSE; end
        A_SAVE1:  begin bk_wr[1] = 1'b1; bk_fld = FLD_SAVE;  end
        A_TVAL1:  begin bk_wr[1] = 1'b1; bk_fld = FLD_TVAL;  end
        default:  ;
      endcase
    end
  end

  logic [NBANK-1:0] bk_cap;
  assign bk_cap = {enter1, enter0};

  logic [W-1:0] bk_rpc   [NBANK];
  logic [W-1:0] bk_save  [NBANK];
  logic [W-1:0] bk_cause [NBANK];
  logic [W-1:0] bk_tval  [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    trap_save_bank #(.TRITS(TRITS)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (triple),
      .capture   (bk_cap[b]),
      .cap_rpc   (pc_c),
      .cap_save  (status_q),
      .cap_cause (cause_w),
      .cap_tval  (tval_w),
      .wr_en     (bk_wr[b]),
      .wr_fld    (bk_fld),
      .wr_data   (wdata_c),
      .rpc_q     (bk_rpc[b]),
      .save_q    (bk_save[b]),
      .cause_q   (bk_cause[b]),
      .tval_q    (bk_tval[b])
    );
  end

  // status word
  logic [W-1:0] status_entry0, status_entry1;
  always_comb begin
    status_entry0 = status_q;
    status_entry0[2*ST_MODE +: 2]  = T_N;
    status_entry0[2*ST_IE +: 2]    = T_N;
    status_entry0[2*ST_DEPTH +: 2] = T_P;
    status_entry1 = status_q;
    status_entry1[2*ST_DEPTH +: 2] = T_N;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || triple)                     status_q <= '0;
    else if (enter0)                          status_q <= status_entry0;
    else if (enter1)                          status_q <= status_entry1;
    else if (ret_take)                        status_q <= bk_save[ret_sel];
    else if (wr_ok && addr_i == A_STATUS)     status_q <= wdata_c;
  end

  // plain stored registers
  always_ff @(posedge clk) begin
    if (!rst_n || triple) begin
      lmode_q  <= '0;
      flags_q  <= '0;
      vector_q <= '0;
    end else if (wr_ok) begin
      if (addr_i == A_LMODE)  lmode_q  <= wdata_c;
      if (addr_i == A_FLAGS)  flags_q  <= wdata_c;
      if (addr_i == A_VECTOR) vector_q <= wdata_c;
    end
  end

  // redirect and machine-check
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      mcheck_reset   <= 1'b0;
    end else begin
      redirect_valid <= trap_req || ret_take;
      mcheck_reset   <= triple;
      if (triple)                 redirect_pc <= '0;
      else if (enter0 || enter1)  redirect_pc <= vector_q;
      else if (ret_take)          redirect_pc <= bk_rpc[ret_sel];
    end
  end

  // CSR read
  always_comb begin
    unique case (addr_i)
      A_PC:     csr_rdata = pc_c;
      A_LMODE:  csr_rdata = lmode_q;
      A_FLAGS:  csr_rdata = flags_q;
      A_RPC0:   csr_rdata = bk_rpc[0];
      A_CAUSE0: csr_rdata = bk_cause[0];
      A_VECTOR: csr_rdata = vector_q;
      A_STATUS: csr_rdata = status_q;
      A_SAVE0:  csr_rdata = bk_save[0];
      A_TVAL0:  csr_rdata = bk_tval[0];
      A_RPC1:   csr_rdata = bk_rpc[1];
      A_CAUSE1: csr_rdata = bk_cause[1];
      A_SAVE1:  csr_rdata = bk_save[1];
      A_TVAL1:  csr_rdata = bk_tval[1];
      default:  csr_rdata = '0;
    endcase
  end

  assign status_out = status_q;
endmodule

// File: rtl/trap_bank_sva.sv
module trap_bank_sva
  import trap_bank_pkg::*;
#(
  parameter int TRITS = WORD_TRITS,
  localparam int W = 2 * TRITS
) (
  input logic         clk,
  input logic         rst_n,
  input logic         trap_req,
  input logic         trap_ret,
  input logic [W-1:0] status_out,
  input logic         redirect_valid,
  input logic [W-1:0] redirect_pc,
  input logic         mcheck_reset
);
  logic [1:0] dep;
  assign dep = status_out[2*ST_DEPTH +: 2];

  function automatic logic has_bad_code(logic [W-1:0] w);
    logic bad;
    bad = 1'b0;
    for (int i = 0; i < TRITS; i++) if (w[2*i +: 2] == 2'b11) bad = 1'b1;
    return bad;
  endfunction

  AST_ENTRY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && dep == T_Z |=> dep == T_P && redirect_valid && !mcheck_reset); // R2

  AST_ENTRY_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && dep == T_P |=> dep == T_N && redirect_valid && $stable(status_out[3:0])); // R3

  AST_TRIPLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && dep == T_N |=> mcheck_reset && status_out == '0 && redirect_pc == '0); // R4

  AST_MCHECK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    mcheck_reset |-> $past(trap_req)); // R4

  AST_RETURN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ret && !trap_req && dep == T_Z |=> !redirect_valid && $stable(status_out)); // R5

  AST_NO_BAD_TRIT: assert property (@(posedge clk) disable iff (!rst_n)
    !has_bad_code(status_out)); // R9
endmodule

bind trap_bank_ctrl trap_bank_sva #(.TRITS(TRITS)) u_trap_bank_sva (
  .clk            (clk),
  .rst_n          (rst_n),
  .trap_req       (trap_req),
  .trap_ret       (trap_ret),
  .status_out     (status_out),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .mcheck_reset   (mcheck_reset)
);

// File: tb/test_trap_bank_ctrl.sv
`timescale 1ns/1ps
module test_trap_bank_ctrl;
  localparam int TRITS = 27;
  localparam int W     = 2 * TRITS;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trap_req = 1'b0;
  logic [1:0]    trap_kind = '0;
  logic [1:0]    trap_flavor = '0;
  logic [W-1:0]  trap_info = '0;
  logic [W-1:0]  cur_pc = '0;
  logic          trap_ret = 1'b0;
  logic          csr_we = 1'b0;
  logic [AW-1:0] csr_addr = '0;
  logic [W-1:0]  csr_wdata = '0;
  logic [W-1:0]  csr_rdata, status_out, redirect_pc;
  logic          redirect_valid, mcheck_reset;

  always #2 clk = ~clk;

  trap_bank_ctrl #(.TRITS(TRITS), .ADDR_W(AW)) i_trap_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_kind(trap_kind),
    .trap_flavor(trap_flavor), .trap_info(trap_info), .cur_pc(cur_pc),
    .trap_ret(trap_ret), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .status_out(status_out),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .mcheck_reset(mcheck_reset)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  function automatic longint to_int(logic [W-1:0] w);
    longint acc = 0;
    for (int i = TRITS - 1; i >= 0; i--) begin
      acc = acc * 3;
      if (w[2*i +: 2] == 2'b01) acc = acc + 1;
      else if (w[2*i +: 2] == 2'b10) acc = acc - 1;
    end
    return acc;
  endfunction

  function automatic logic [W-1:0] from_int(longint v);
    logic [W-1:0] w = '0;
    longint x = v;
    for (int i = 0; i < TRITS; i++) begin
      longint m = ((x % 3) + 3) % 3;
      if (m == 1) begin w[2*i +: 2] = 2'b01; x = (x - 1) / 3; end
      else if (m == 2) begin w[2*i +: 2] = 2'b10; x = (x + 1) / 3; end
      else x = x / 3;
    end
    return w;
  endfunction

  function automatic logic [W-1:0] clean(logic [W-1:0] w);
    logic [W-1:0] r = w;
    for (int i = 0; i < TRITS; i++) if (r[2*i +: 2] == 2'b11) r[2*i +: 2] = 2'b00;
    return r;
  endfunction

  // ---------------- reference model ----------------
  logic [W-1:0] m_reg [0:15];
  logic         m_rv = 1'b0, m_mc = 1'b0;
  logic [W-1:0] m_rpc = '0;

  function automatic logic [W-1:0] model_cause(logic [1:0] k, logic [1:0] f);
    case (k)
      2'b00: return from_int(-13);
      2'b01: return from_int(-11);
      2'b10: return from_int(-10);
      default: return (f == 2'b01) ? from_int(1) : (f == 2'b10) ? from_int(2) : from_int(0);
    endcase
  endfunction

  always @(posedge clk) begin : model_step
    logic [1:0] d;
    logic [W-1:0] c, t;
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) m_reg[i] = '0;
      m_rv = 1'b0; m_mc = 1'b0; m_rpc = '0;
    end else begin
      d = m_reg[7][5:4];
      m_rv = 1'b0; m_mc = 1'b0;
      c = model_cause(trap_kind, trap_flavor);
      t = (trap_kind == 2'b01 || trap_kind == 2'b10) ? clean(trap_info) : '0;
      if (trap_req) begin
        if (d == 2'b00) begin
          m_reg[8] = m_reg[7]; m_reg[4] = clean(cur_pc); m_reg[5] = c; m_reg[9] = t;
          m_reg[7][1:0] = 2'b10; m_reg[7][3:2] = 2'b10; m_reg[7][5:4] = 2'b01;
          m_rv = 1'b1; m_rpc = m_reg[6];
        end else if (d == 2'b01) begin
          m_reg[12] = m_reg[7]; m_reg[10] = clean(cur_pc); m_reg[11] = c; m_reg[13] = t;
          m_reg[7][5:4] = 2'b10;
          m_rv = 1'b1; m_rpc = m_reg[6];
        end else begin
          for (int i = 0; i < 16; i++) m_reg[i] = '0;
          m_mc = 1'b1; m_rv = 1'b1; m_rpc = '0;
        end
      end else if (trap_ret) begin
        if (d == 2'b01) begin m_rpc = m_reg[4]; m_reg[7] = m_reg[8]; m_rv = 1'b1; end
        else if (d == 2'b10) begin m_rpc = m_reg[10]; m_reg[7] = m_reg[12]; m_rv = 1'b1; end
      end else if (csr_we && csr_addr >= 2 && csr_addr <= 13) begin
        m_reg[csr_addr] = clean(csr_wdata);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [W-1:0] exp_rd;
    if (csr_addr == 1) exp_rd = clean(cur_pc);
    else if (csr_addr >= 2 && csr_addr <= 13) exp_rd = m_reg[csr_addr];
    else exp_rd = '0;
    chk(status_out === m_reg[7], "MODEL status", status_out, m_reg[7]);
    chk(redirect_valid === m_rv, "MODEL redirect_valid", W'(redirect_valid), W'(m_rv));
    chk(mcheck_reset === m_mc, "MODEL mcheck_reset", W'(mcheck_reset), W'(m_mc));
    if (m_rv) chk(redirect_pc === m_rpc, "MODEL redirect_pc", redirect_pc, m_rpc);
    chk(csr_rdata === exp_rd, "MODEL csr_rdata", csr_rdata, exp_rd);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic rd(input int a, input logic [W-1:0] exp, input string tag);
    csr_addr = AW'(a);
    #1;
    chk(csr_rdata === exp, tag, csr_rdata, exp);
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    csr_we = 1'b1; csr_addr = AW'(a); csr_wdata = d;
    tick();
    csr_we = 1'b0;
  endtask

  task automatic trap(input logic [1:0] k, input logic [1:0] f, input logic [W-1:0] info);
    trap_req = 1'b1; trap_kind = k; trap_flavor = f; trap_info = info;
    tick();
    trap_req = 1'b0;
  endtask

  task automatic tret();
    trap_ret = 1'b1;
    tick();
    trap_ret = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(status_out === '0, "R1 status", status_out, '0);
    chk(!redirect_valid && !mcheck_reset, "R1 strobes", W'({redirect_valid, mcheck_reset}), '0);
    rd(6, '0, "R1 vector");
    rd(12, '0, "R1 nested save");

    // R8 / R9 map, ignored PC write, code 11 cleaning
    cur_pc = from_int(1000);
    wr(6, from_int(500));
    wr(1, from_int(77));
    rd(1, from_int(1000), "R8 PC reads cur_pc");
    wr(2, {TRITS{2'b11}});
    rd(2, '0, "R9 code 11 stored as Z");
    wr(3, from_int(-4));
    rd(3, from_int(-4), "R8 flags");
    rd(0, '0, "R8 address 0");
    rd(14, '0, "R8 address 14");
    wr(7, 54'h405);

    // R2 first trap, access fault
    trap(2'b01, 2'b00, from_int(77));
    chk(redirect_valid && redirect_pc === from_int(500), "R2 redirect", redirect_pc, from_int(500));
    chk(status_out === 54'h41A, "R2 status", status_out, 54'h41A);
    rd(8, 54'h405, "R2 saved status");
    rd(4, from_int(1000), "R2 return pc");
    chk(to_int(i_read(5)) == -11, "R6 fault cause", i_read(5), from_int(-11));
    rd(9, from_int(77), "R6 fault value");

    // R3 + R10: nested trap with simultaneous return and write
    cur_pc = from_int(2000);
    trap_ret = 1'b1; csr_we = 1'b1; csr_addr = 4'd6; csr_wdata = from_int(9);
    trap(2'b10, 2'b00, from_int(1234));
    trap_ret = 1'b0; csr_we = 1'b0;
    chk(status_out === 54'h42A, "R10 trap wins, R3 depth N", status_out, 54'h42A);
    chk(redirect_pc === from_int(500), "R3 redirect", redirect_pc, from_int(500));
    rd(6, from_int(500), "R10 write dropped");
    rd(5, from_int(-11), "R3 primary cause kept");
    rd(11, from_int(-10), "R6 illegal cause");
    rd(13, from_int(1234), "R6 illegal value");
    rd(12, 54'h41A, "R3 nested saved status");

    // R5 returns
    tret();
    chk(redirect_valid && redirect_pc === from_int(2000), "R5 nested return pc", redirect_pc, from_int(2000));
    chk(status_out === 54'h41A, "R5 nested status", status_out, 54'h41A);
    tret();
    chk(redirect_pc === from_int(1000), "R5 primary return pc", redirect_pc, from_int(1000));
    chk(status_out === 54'h405, "R5 primary status", status_out, 54'h405);
    tret();
    chk(!redirect_valid && status_out === 54'h405, "R5 return at Z ignored", status_out, 54'h405);

    // R6/R7 call flavours and divide by zero
    trap(2'b11, 2'b00, from_int(33));
    rd(5, from_int(0), "R7 user call");
    rd(9, '0, "R6 call value zero");
    tret();
    trap(2'b11, 2'b01, '0);
    rd(5, from_int(1), "R7 hypercall");
    tret();
    trap(2'b11, 2'b10, '0);
    rd(5, from_int(2), "R7 debug trap");
    tret();
    trap(2'b11, 2'b11, '0);
    rd(5, from_int(0), "R7 flavour 11 as Z");
    tret();
    trap(2'b00, 2'b00, from_int(5));
    rd(5, from_int(-13), "R6 divide cause");
    rd(9, '0, "R6 divide value");
    tret();
    trap(2'b01, 2'b00, {TRITS{2'b11}});
    rd(9, '0, "R9 info code 11");
    tret();

    // R4 triple fault
    trap(2'b00, 2'b00, '0);
    trap(2'b00, 2'b00, '0);
    trap(2'b00, 2'b00, '0);
    chk(mcheck_reset && redirect_valid && redirect_pc === '0, "R4 mcheck", redirect_pc, '0);
    chk(status_out === '0, "R4 status cleared", status_out, '0);
    rd(6, '0, "R4 vector cleared");
    rd(3, '0, "R4 flags cleared");
    tick();
    chk(!mcheck_reset, "R4 single pulse", W'(mcheck_reset), '0);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      trap_req    = ($urandom_range(0, 9) == 0);
      trap_kind   = 2'($urandom);
      trap_flavor = 2'($urandom);
      trap_info   = {$urandom, $urandom};
      cur_pc      = {$urandom, $urandom};
      trap_ret    = ($urandom_range(0, 7) == 0);
      csr_we      = ($urandom_range(0, 2) == 0);
      csr_addr    = AW'($urandom);
      csr_wdata   = {$urandom, $urandom};
      tick();
    end
    trap_req = 1'b0; trap_ret = 1'b0; csr_we = 1'b0;
    tick();
    finish_run();
  end

  function automatic logic [W-1:0] i_read(input int a);
    return (a == 5) ? m_reg[5] : '0;
  endfunction
endmodule